// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Word Protector

This block guards an 8-bit memory word with a single-error-correcting Hamming code. On the write side it turns a data byte into a 12-bit codeword by adding four check bits. On the read side it takes a 12-bit word fetched from storage, recomputes the check bits and compares them with the stored ones to form a 4-bit syndrome. It then repairs a single flipped data bit and reports one of four outcomes.

Both sides are independent pipelines of one register each, and each is qualified by a valid strobe. Faults are treated as soft and transient. Correction applies only to the word that is handed back, so storage is never rewritten. The surrounding memory controller places the codeword in its array and later feeds it back to the read side.

Top module: `hsec_protect`

## Requirements
- R1: The code uses K = 4 check bits, the smallest K with 2^K - 1 >= 8 + K, so a codeword is 12 bits wide. Codeword position p (1..12) is bit p-1 of the word. Check bits occupy positions 1, 2, 4 and 8. Data bits wr_data[0]..wr_data[7] occupy positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: The check bit at position 2^i is the XOR of every data bit whose position number has bit i set.
- R3: enc_valid goes high exactly one cycle after wr_valid is sampled high, and enc_word holds the codeword of that byte. enc_valid is low in any cycle that follows one without wr_valid.
- R4: dec_valid goes high exactly one cycle after rd_valid is sampled high, and low after a cycle without rd_valid.
- R5: dec_syndrome is the bitwise XOR of the four stored check bits and the four check bits recomputed from the data bits of the read word.
- R6: A zero syndrome raises flag_clean only, and dec_data equals the data bits of the read word.
- R7: A syndrome with exactly one bit set raises flag_chk only, and dec_data equals the data bits of the read word, with no correction applied.
- R8: A syndrome of 3, 5, 6, 7, 9, 10, 11 or 12 raises flag_fixed only. dec_data comes from the read word with the bit at that codeword position inverted.
- R9: A syndrome of 13, 14 or 15 raises flag_bad only, and dec_data equals the uncorrected data bits of the read word.
- R10: While dec_valid is high exactly one of the four flags is high. While dec_valid is low all four flags are low.
- R11: A synchronous active-high rst clears enc_valid, dec_valid and all four flags on the next clock edge, whatever the valid inputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write byte is present |
| wr_data | input | 8 | Byte to encode |
| enc_valid | output | 1 | Codeword output is valid |
| enc_word | output | 12 | Encoded 12-bit codeword |
| rd_valid | input | 1 | Read word is present |
| rd_word | input | 12 | Codeword fetched from storage |
| dec_valid | output | 1 | Decode result is valid |
| dec_data | output | 8 | Delivered (possibly corrected) byte |
| dec_syndrome | output | 4 | Syndrome of the decoded word |
| flag_clean | output | 1 | No error found |
| flag_chk | output | 1 | Single check-bit error, data untouched |
| flag_fixed | output | 1 | Data bit inverted at the syndrome position |
| flag_bad | output | 1 | Syndrome names no position, data untouched |

## Verification
Every stage is a single register, so any wrong internal value shows at the ports in the cycle right after the input is sampled. A wrong check equation gives a nonzero syndrome on a clean codeword, and a flag other than flag_clean then appears one cycle later. A misrouted correction changes dec_data in that same cycle, in one or more bits other than the flipped one. A broken classification shows as zero or several flags, or as the wrong flag for a syndrome. Every byte is read back with each single-bit flip, and double flips reach the codes that name no position.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  localparam int DATA_W = 8;

  // smallest k with 2^k - 1 >= m + k
  function automatic int check_count(int m);
    int k;
    k = 0;
    for (int t = 16; t >= 1; t--) begin
      if ((1 << t) - 1 >= m + t) k = t;
    end
    return k;
  endfunction

  localparam int CHK_W  = check_count(DATA_W);
  localparam int WORD_W = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  syn_t;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_CHK   = 2'd1,
    CLS_FIX   = 2'd2,
    CLS_BAD   = 2'd3
  } cls_t;

  function automatic logic is_check_pos(int p);
    return ((p & (p - 1)) == 0);
  endfunction

  // scatter data bits into non-power-of-two positions
  function automatic word_t place_data(data_t d);
    word_t w;
    int di;
    w  = '0;
    di = 0;
    for (int p = 1; p <= WORD_W; p++) begin
      if (!is_check_pos(p)) begin
        w[p-1] = d[di];
        di++;
      end
    end
    return w;
  endfunction

  // gather data bits back out of a codeword
  function automatic data_t pick_data(word_t w);
    data_t d;
    int di;
    d  = '0;
    di = 0;
    for (int p = 1; p <= WORD_W; p++) begin
      if (!is_check_pos(p)) begin
        d[di] = w[p-1];
        di++;
      end
    end
    return d;
  endfunction

  // check bits from the data positions: XOR of the position numbers of set data bits
  function automatic syn_t check_of_word(word_t w);
    syn_t c;
    c = '0;
    for (int p = 1; p <= WORD_W; p++) begin
      if (!is_check_pos(p) && w[p-1]) c = c ^ syn_t'(p);
    end
    return c;
  endfunction

  // check bits as held in the word
  function automatic syn_t stored_check(word_t w);
    syn_t c;
    for (int i = 0; i < CHK_W; i++) c[i] = w[(1 << i) - 1];
    return c;
  endfunction

  function automatic word_t put_check(word_t w, syn_t c);
    word_t r;
    r = w;
    for (int i = 0; i < CHK_W; i++) r[(1 << i) - 1] = c[i];
    return r;
  endfunction

  function automatic cls_t classify(syn_t s);
    cls_t c;
    if (s == '0)                 c = CLS_CLEAN;
    else if ($countones(s) == 1) c = CLS_CHK;
    else if (int'(s) <= WORD_W)  c = CLS_FIX;
    else                         c = CLS_BAD;
    return c;
  endfunction

  function automatic data_t repair(word_t w, syn_t s, cls_t c);
    word_t r;
    r = w;
    if (c == CLS_FIX) r[int'(s) - 1] = ~r[int'(s) - 1];
    return pick_data(r);
  endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder
  import hsec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  data_t in_data,
  output logic  out_valid,
  output word_t out_word
);

  word_t spread;
  syn_t  chk;

  always_comb begin
    spread = place_data(in_data);
    chk    = check_of_word(spread);
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_word <= put_check(spread, chk);
  end

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome
  import hsec_pkg::*;
(
  input  word_t in_word,
  output syn_t  syn,
  output cls_t  cls
);

  always_comb begin
    syn = stored_check(in_word) ^ check_of_word(in_word);
    cls = classify(syn);
  end

endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector
  import hsec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  word_t in_word,
  input  syn_t  in_syn,
  input  cls_t  in_cls,
  output logic  out_valid,
  output data_t out_data,
  output syn_t  out_syn,
  output logic  out_clean,
  output logic  out_chk,
  output logic  out_fixed,
  output logic  out_bad
);

  logic [3:0] flag_d;

  always_comb begin
    flag_d = '0;
    flag_d[in_cls] = 1'b1;
    if (!in_valid) flag_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_clean <= 1'b0;
      out_chk   <= 1'b0;
      out_fixed <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_clean <= flag_d[CLS_CLEAN];
      out_chk   <= flag_d[CLS_CHK];
      out_fixed <= flag_d[CLS_FIX];
      out_bad   <= flag_d[CLS_BAD];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_data <= repair(in_word, in_syn, in_cls);
      out_syn  <= in_syn;
    end
  end

endmodule

// File: rtl/hsec_protect.sv
module hsec_protect
  import hsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enc_valid,
  output logic [WORD_W-1:0] enc_word,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_word,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic [CHK_W-1:0]  dec_syndrome,
  output logic              flag_clean,
  output logic              flag_chk,
  output logic              flag_fixed,
  output logic              flag_bad
);

  syn_t rd_syn;
  cls_t rd_cls;

  hsec_encoder enc_u (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (wr_valid),
    .in_data   (wr_data),
    .out_valid (enc_valid),
    .out_word  (enc_word)
  );

  hsec_syndrome syn_u (
    .in_word (rd_word),
    .syn     (rd_syn),
    .cls     (rd_cls)
  );

  hsec_corrector cor_u (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_valid),
    .in_word   (rd_word),
    .in_syn    (rd_syn),
    .in_cls    (rd_cls),
    .out_valid (dec_valid),
    .out_data  (dec_data),
    .out_syn   (dec_syndrome),
    .out_clean (flag_clean),
    .out_chk   (flag_chk),
    .out_fixed (flag_fixed),
    .out_bad   (flag_bad)
  );

endmodule

// File: rtl/hsec_protect_chk.sv
module hsec_protect_chk
  import hsec_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  wr_valid,
  input logic  enc_valid,
  input word_t enc_word,
  input logic  rd_valid,
  input word_t rd_word,
  input syn_t  rd_syn,
  input logic  dec_valid,
  input data_t dec_data,
  input syn_t  dec_syndrome,
  input logic  flag_clean,
  input logic  flag_chk,
  input logic  flag_fixed,
  input logic  flag_bad
);

  logic [3:0] flags;
  assign flags = {flag_clean, flag_chk, flag_fixed, flag_bad};

  assert_enc_rise_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> enc_valid);
  assert_enc_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> !enc_valid);
  assert_enc_code_R2: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (check_of_word(enc_word) == stored_check(enc_word)));
  assert_dec_rise_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> dec_valid);
  assert_dec_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !dec_valid);
  assert_syn_carry_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (dec_syndrome == $past(rd_syn)));
  assert_one_flag_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($countones(flags) == 1));
  assert_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (flags == 4'b0));
  assert_clean_pass_R6: assert property (@(posedge clk) disable iff (rst)
    flag_clean |-> (dec_data == $past(pick_data(rd_word)) && dec_syndrome == '0));
  assert_chk_pass_R7: assert property (@(posedge clk) disable iff (rst)
    flag_chk |-> (dec_data == $past(pick_data(rd_word)) && $countones(dec_syndrome) == 1));
  assert_fix_single_R8: assert property (@(posedge clk) disable iff (rst)
    flag_fixed |-> ($countones(dec_data ^ $past(pick_data(rd_word))) == 1));
  assert_bad_pass_R9: assert property (@(posedge clk) disable iff (rst)
    flag_bad |-> (dec_data == $past(pick_data(rd_word)) && int'(dec_syndrome) > WORD_W));
  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(rst) |-> (!enc_valid && !dec_valid && flags == 4'b0));

endmodule

bind hsec_protect hsec_protect_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .wr_valid     (wr_valid),
  .enc_valid    (enc_valid),
  .enc_word     (enc_word),
  .rd_valid     (rd_valid),
  .rd_word      (rd_word),
  .rd_syn       (rd_syn),
  .dec_valid    (dec_valid),
  .dec_data     (dec_data),
  .dec_syndrome (dec_syndrome),
  .flag_clean   (flag_clean),
  .flag_chk     (flag_chk),
  .flag_fixed   (flag_fixed),
  .flag_bad     (flag_bad)
);

// File: tb/hsec_protect_tb.sv
module hsec_protect_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        enc_valid;
  logic [11:0] enc_word;
  logic        rd_valid = 1'b0;
  logic [11:0] rd_word = '0;
  logic        dec_valid;
  logic [7:0]  dec_data;
  logic [3:0]  dec_syndrome;
  logic        flag_clean, flag_chk, flag_fixed, flag_bad;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsec_protect dut_i (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .enc_valid(enc_valid), .enc_word(enc_word),
    .rd_valid(rd_valid), .rd_word(rd_word),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_syndrome(dec_syndrome),
    .flag_clean(flag_clean), .flag_chk(flag_chk),
    .flag_fixed(flag_fixed), .flag_bad(flag_bad)
  );

  // R1 R2: explicit parity equations
  function automatic logic [11:0] tb_encode(logic [7:0] d);
    logic c1, c2, c4, c8;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    return {d[7], d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
  endfunction

  function automatic logic [7:0] tb_data(logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  // syndrome as XOR of the position numbers of every set bit
  function automatic logic [3:0] tb_syn(logic [11:0] w);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ 4'(p);
    return s;
  endfunction

  // expected flags {clean, chk, fixed, bad}
  function automatic logic [3:0] tb_flags(logic [3:0] s);
    case (s)
      4'd0:                         return 4'b1000;
      4'd1, 4'd2, 4'd4, 4'd8:       return 4'b0100;
      4'd13, 4'd14, 4'd15:          return 4'b0001;
      default:                      return 4'b0010;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    logic [11:0] exp;
    exp = tb_encode(d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(enc_valid === 1'b1, "R3", "enc_valid after write", 32'(enc_valid), 1);
    check(enc_word === exp, "R1/R2", "enc_word", 32'(enc_word), 32'(exp));
    @(negedge clk);
    check(enc_valid === 1'b0, "R3", "enc_valid idle", 32'(enc_valid), 0);
  endtask

  task automatic do_read(input logic [11:0] w);
    logic [3:0]  s;
    logic [3:0]  f;
    logic [11:0] fixed_w;
    logic [7:0]  exp_d;
    string       req;
    s = tb_syn(w);
    f = tb_flags(s);
    fixed_w = w;
    if (f == 4'b0010) fixed_w[s-1] = ~fixed_w[s-1];
    exp_d = tb_data(fixed_w);
    case (f)
      4'b1000: req = "R6";
      4'b0100: req = "R7";
      4'b0010: req = "R8";
      default: req = "R9";
    endcase
    @(negedge clk);
    rd_valid = 1'b1;
    rd_word  = w;
    @(negedge clk);
    rd_valid = 1'b0;
    check(dec_valid === 1'b1, "R4", "dec_valid after read", 32'(dec_valid), 1);
    check(dec_syndrome === s, "R5", "dec_syndrome", 32'(dec_syndrome), 32'(s));
    check(dec_data === exp_d, req, "dec_data", 32'(dec_data), 32'(exp_d));
    check({flag_clean, flag_chk, flag_fixed, flag_bad} === f, "R10", "flags",
          32'({flag_clean, flag_chk, flag_fixed, flag_bad}), 32'(f));
  endtask

  initial begin
    logic [11:0] cw;
    void'($urandom(32'd1357));
    // R11: valids held high during reset must not leak out
    wr_valid = 1'b1;
    rd_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(enc_valid === 1'b0, "R11", "enc_valid in reset", 32'(enc_valid), 0);
    check(dec_valid === 1'b0, "R11", "dec_valid in reset", 32'(dec_valid), 0);
    check({flag_clean, flag_chk, flag_fixed, flag_bad} === 4'b0, "R11", "flags in reset",
          32'({flag_clean, flag_chk, flag_fixed, flag_bad}), 0);
    wr_valid = 1'b0;
    rd_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(dec_valid === 1'b0, "R4", "dec_valid idle", 32'(dec_valid), 0);
    check({flag_clean, flag_chk, flag_fixed, flag_bad} === 4'b0, "R10", "flags idle",
          32'({flag_clean, flag_chk, flag_fixed, flag_bad}), 0);

    // every byte, clean read plus every single-bit flip (R6 R7 R8)
    for (int d = 0; d < 256; d++) begin
      do_write(8'(d));
      cw = tb_encode(8'(d));
      do_read(cw);
      for (int p = 1; p <= 12; p++) do_read(cw ^ (12'd1 << (p - 1)));
    end

    // directed double flips landing on syndromes 13, 14, 15 (R9)
    do_read(tb_encode(8'hA5) ^ 12'h090);
    do_read(tb_encode(8'h3C) ^ 12'h0A0);
    do_read(tb_encode(8'hFF) ^ 12'h0C0);

    // random double flips
    for (int n = 0; n < 300; n++) begin
      int a, b;
      a = int'($urandom % 12);
      b = int'($urandom % 12);
      if (a == b) b = (b + 1) % 12;
      do_read(tb_encode(8'($urandom)) ^ (12'd1 << a) ^ (12'd1 << b));
    end

    // back-to-back writes: codeword follows each byte one cycle later (R3)
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'h5A;
    @(negedge clk);
    wr_data  = 8'hC3;
    check(enc_word === tb_encode(8'h5A), "R3", "burst word 0", 32'(enc_word), 32'(tb_encode(8'h5A)));
    @(negedge clk);
    wr_valid = 1'b0;
    check(enc_word === tb_encode(8'hC3), "R3", "burst word 1", 32'(enc_word), 32'(tb_encode(8'hC3)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule